// File: doc/BRIEF.md
# Signed-Frequency Complex Oscillator

This block is a numerically controlled oscillator that produces a quadrature pair (cosine and sine) for any frequency between minus and plus half the sample rate, including zero. A signed tuning word is added to a 32-bit phase register on every sample enable. The phase register uses the whole two's-complement range as one turn: the largest positive value stands for an angle just below +π and the most negative value for -π. Wrap-around therefore comes from plain integer overflow and needs no modulo logic.

The phase drives a 256-entry sine table. The upper phase bits select a table entry, and the remaining phase bits form a fraction that interpolates linearly towards the next entry. Cosine reads the same table with the address moved forward by a quarter turn. A positive tuning word makes the pair rotate forward, a negative one makes it rotate backward, and zero freezes it. Each output pair comes with a valid flag two clock edges after the enable that requested it.

Top module: `signed_nco`

## Requirements
- R1: While rst_ni is low and after its release, the phase is zero, valid_o is 0 and cos_o and sin_o are 0.
- R2: When en_i is high at a rising edge, valid_o is high for exactly the cycle that follows the next rising edge. It is a two-edge latency, and valid_o is low in every other cycle.
- R3: Each enabled edge adds tune_i, taken as signed, to the phase modulo 2^32. Edges without an enable leave the phase unchanged.
- R4: The output pair for an enable uses the phase as it stood before that enable's addition. The first pair after reset is therefore cos_o = 32767 and sin_o = 0.
- R5: The table is T[k] = trunc(32767*sin(2πk/256)) for k = 0..255, with k = phase[31:24] as an unsigned index and f = phase[23:0]. The sine output is T[k] + floor((T[(k+1) mod 256] - T[k]) * f / 2^24). The cosine output uses the same formula with k replaced by (k+64) mod 256.
- R6: A negative tuning word gives a backward rotation. For example, tune_i = -2^24 steps the index down by one entry per sample.
- R7: Phase sums past +π wrap into negative angles with no saturation. Examples are the tuning words 0x7FFFFFFF and 0x80000000, and quarter-turn steps.
- R8: With tune_i = 0, successive outputs are identical and keep the rotation already reached.
- R9: cos_o and sin_o keep their values in cycles where valid_o is low.
- R10: cos_o and sin_o never take the value -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample enable: produce one output pair and advance the phase |
| tune_i | input | 32 | Signed phase increment per sample |
| cos_o | output | 16 | Signed cosine sample |
| sin_o | output | 16 | Signed sine sample |
| valid_o | output | 1 | Output pair is new in this cycle |

## Verification
The bound checker tests the following on every cycle:
- the two-edge enable-to-valid latency;
- the phase step by the signed tuning word, and the phase hold without an enable;
- the frozen phase under a zero tuning word;
- output stability while valid_o is low;
- the excluded code -32768.

Only the bench scenarios can show the actual sample values, by comparing each pair with a table-and-interpolation model computed from the sine formula. These scenarios cover:
- forward rotation and backward rotation;
- wrap-around at ±π with extreme tuning words;
- the full-scale first sample after reset.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int PHASE_W = 32;
  localparam int ADDR_W  = 8;
  localparam int OUT_W   = 16;

  // Truncated sine table entry for index k of a depth-entry turn
  function automatic int sine_entry(input int k, input int depth, input int amp);
    real ang;
    ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(depth);
    return $rtoi(real'(amp) * $sin(ang));
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tune_i,
  output logic [PHASE_W-1:0] phase_o
);
  // two's-complement wrap is the modulo
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_o <= '0;
    else if (en_i) phase_o <= phase_o + tune_i;
  end
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic [ADDR_W-1:0]       lo_addr_i,
  output logic signed [OUT_W-1:0] lo_o,
  output logic signed [OUT_W-1:0] hi_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << (OUT_W - 1)) - 1;

  logic signed [OUT_W-1:0] tbl [DEPTH];
  logic [ADDR_W-1:0]       hi_addr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    localparam int VAL = nco_pkg::sine_entry(g, DEPTH, AMP);
    assign tbl[g] = OUT_W'(VAL);
  end

  assign hi_addr = lo_addr_i + ADDR_W'(1);
  assign lo_o    = tbl[lo_addr_i];
  assign hi_o    = tbl[hi_addr];
endmodule

// File: rtl/nco_interp.sv
module nco_interp #(
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic signed [OUT_W-1:0] lo_i,
  input  logic signed [OUT_W-1:0] hi_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int DIFF_W = OUT_W + 1;
  localparam int PROD_W = DIFF_W + FRAC_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] step;
  logic signed [PROD_W-1:0] sum;

  assign diff = DIFF_W'(hi_i) - DIFF_W'(lo_i);
  assign prod = PROD_W'(diff) * $signed({1'b0, frac_i});
  assign step = prod >>> FRAC_W;   // floor division by 2^FRAC_W
  assign sum  = PROD_W'(lo_i) + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (load_i) val_o <= sum[OUT_W-1:0];
  end
endmodule

// File: rtl/signed_nco.sv
module signed_nco #(
  parameter int PHASE_W = nco_pkg::PHASE_W,
  parameter int ADDR_W  = nco_pkg::ADDR_W,
  parameter int OUT_W   = nco_pkg::OUT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tune_i,
  output logic [OUT_W-1:0]   cos_o,
  output logic [OUT_W-1:0]   sin_o,
  output logic               valid_o
);
  localparam int FRAC_W  = PHASE_W - ADDR_W;
  localparam int QUARTER = 1 << (ADDR_W - 2);
  localparam int N_CH    = 2;  // 0: sine, 1: cosine

  logic [PHASE_W-1:0] phase_q;
  logic [ADDR_W-1:0]  idx_q [N_CH];
  logic [FRAC_W-1:0]  frac_q;
  logic               vld1_q;
  logic               valid_q;
  logic signed [OUT_W-1:0] sample [N_CH];

  nco_phase_acc #(.PHASE_W(PHASE_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tune_i  (tune_i),
    .phase_o (phase_q)
  );

  // stage 1: capture pre-advance phase as index and fraction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q[0] <= '0;
      idx_q[1] <= '0;
      frac_q   <= '0;
      vld1_q   <= 1'b0;
    end else begin
      vld1_q <= en_i;
      if (en_i) begin
        idx_q[0] <= phase_q[PHASE_W-1 -: ADDR_W];
        idx_q[1] <= phase_q[PHASE_W-1 -: ADDR_W] + ADDR_W'(QUARTER);
        frac_q   <= phase_q[FRAC_W-1:0];
      end
    end
  end

  // stage 2: table read and interpolation per channel
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic signed [OUT_W-1:0] lo, hi;

    nco_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) i_rom (
      .lo_addr_i (idx_q[g]),
      .lo_o      (lo),
      .hi_o      (hi)
    );

    nco_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) i_interp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (vld1_q),
      .lo_i   (lo),
      .hi_i   (hi),
      .frac_i (frac_q),
      .val_o  (sample[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= vld1_q;
  end

  assign sin_o   = sample[0];
  assign cos_o   = sample[1];
  assign valid_o = valid_q;
endmodule

// File: rtl/signed_nco_checker.sv
module signed_nco_checker #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [PHASE_W-1:0] tune_i,
  input logic [PHASE_W-1:0] phase_q,
  input logic [OUT_W-1:0]   cos_o,
  input logic [OUT_W-1:0]   sin_o,
  input logic               valid_o
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] cyc_q;  // edges since reset, saturating at 3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (valid_o == $past(en_i, 2)));

  assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && $past(en_i)) |-> (phase_q == $past(phase_q) + $past(tune_i)));

  assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !$past(en_i)) |-> $stable(phase_q));

  assert_zero_tune_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && $past(tune_i) == '0) |-> $stable(phase_q));

  assert_hold_outputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !valid_o) |-> ($stable(cos_o) && $stable(sin_o)));

  assert_no_most_neg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cos_o != MOST_NEG) && (sin_o != MOST_NEG));
endmodule

bind signed_nco signed_nco_checker #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) i_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .tune_i  (tune_i),
  .phase_q (phase_q),
  .cos_o   (cos_o),
  .sin_o   (sin_o),
  .valid_o (valid_o)
);

// File: tb/test_signed_nco.sv
module test_signed_nco;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] tune_i = '0;
  logic [15:0] cos_o, sin_o;
  logic        valid_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] ref_ph = '0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  signed_nco i_signed_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tune_i(tune_i),
    .cos_o(cos_o), .sin_o(sin_o), .valid_o(valid_o)
  );

  localparam int NV = 9;
  localparam logic [31:0] VEC_TUNE [NV] = '{
    32'h0100_0000, 32'hFF00_0000, 32'h0123_4567, 32'hFEDC_BA99, 32'h4000_0000,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hC000_0000 };
  localparam int VEC_N [NV] = '{6, 6, 5, 5, 5, 4, 4, 3, 5};
  localparam string VEC_REQ [NV] = '{"R5", "R6", "R5", "R6", "R7", "R7", "R7", "R3", "R6"};

  function automatic int tbl(input int k);
    return $rtoi(32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(k % 256) / 256.0));
  endfunction

  function automatic int ref_val(input logic [31:0] ph, input bit is_cos);
    int k;
    longint a, b, f, d;
    k = int'(ph[31:24]) + (is_cos ? 64 : 0);
    a = tbl(k);
    b = tbl(k + 1);
    f = longint'(ph[23:0]);
    d = b - a;
    return int'(a + ((d * f) >>> 24));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pair(input string req, input logic [31:0] ph);
    chk(req, int'($signed(cos_o)), ref_val(ph, 1'b1));
    chk(req, int'($signed(sin_o)), ref_val(ph, 1'b0));
  endtask

  // one isolated enable; checks latency and the pair for ref_ph
  task automatic single(input string req, input logic [31:0] tw);
    @(negedge clk_i);
    en_i = 1'b1; tune_i = tw;
    @(posedge clk_i);
    @(negedge clk_i);
    en_i = 1'b0;
    chk("R2", int'(valid_o), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2", int'(valid_o), 1);
    chk_pair(req, ref_ph);
    ref_ph = ref_ph + tw;
  endtask

  // back-to-back enables; output i checked two negedges after it is requested
  task automatic burst(input string req, input logic [31:0] tw, input int n);
    logic [31:0] base;
    base = ref_ph;
    tune_i = tw;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        chk("R2", int'(valid_o), 1);
        chk_pair(req, base + tw * 32'(i - 2));
      end
      en_i = (i < n);
    end
    ref_ph = base + tw * 32'(n);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] c0, s0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", int'(valid_o), 0);
    chk("R1", int'(cos_o), 0);
    chk("R1", int'(sin_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", int'(valid_o), 0);

    // R4: first pair after reset is full-scale cosine, zero sine
    single("R4", 32'h0100_0000);
    chk("R4", int'($signed(cos_o)), 32767);
    chk("R4", int'($signed(sin_o)), 0);

    // vector table walk, isolated enables
    for (int v = 0; v < NV; v++)
      for (int s = 0; s < VEC_N[v]; s++)
        single(VEC_REQ[v], VEC_TUNE[v]);

    // R9: outputs hold with enable low
    c0 = cos_o; s0 = sin_o;
    repeat (5) @(negedge clk_i);
    chk("R9", int'(cos_o), int'(c0));
    chk("R9", int'(sin_o), int'(s0));
    chk("R2", int'(valid_o), 0);

    // R3: phase must not have moved during idle cycles
    single("R3", 32'h0000_0000);

    // continuous enables, forward and backward
    burst("R5", 32'h0A3D_70A4, 12);
    burst("R6", 32'hF5C2_8F5C, 12);
    burst("R7", 32'h7FFF_FFFF, 6);

    // R8: zero tuning word freezes the rotation
    burst("R8", 32'h0000_0000, 6);
    chk("R8", int'($signed(cos_o)), ref_val(ref_ph, 1'b1));
    chk("R8", int'($signed(sin_o)), ref_val(ref_ph, 1'b0));

    // R10: sweep many phases; outputs never hit -32768
    for (int i = 0; i < 64; i++) begin
      single("R10", 32'h0404_0405);
      checks++;
      if (cos_o == 16'h8000 || sin_o == 16'h8000) begin
        errors++;
        $display("FAIL R10: actual=%0d/%0d expected=not -32768",
                 $signed(cos_o), $signed(sin_o));
      end
    end

    // R1: reset mid-run clears outputs and phase
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", int'(cos_o), 0);
    chk("R1", int'(valid_o), 0);
    rst_ni = 1'b1;
    ref_ph = '0;
    single("R1", 32'hC000_0000);
    chk("R1", int'($signed(cos_o)), 32767);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule